// File: doc/BRIEF.md
# Dual-Role Byte Serial Link Controller

This block moves one byte at a time over a four-wire synchronous serial bus. It can act as the clock-driving initiator (master) or as a responder (slave). A small control port selects the role, the clock divider and the source of the select level. A parallel port loads the byte to send and returns the byte received. Every exchange is full duplex: eight bits leave most significant bit first while eight bits arrive, both timed by the serial clock that the master drives. The serial clock idles low. Data is sampled on the rising edge and changed on the falling edge.

The effective select level comes from one of two places. It can be the external active-low select pin, or an internal level bit held in the control port. As a slave, the block shifts only while this level is low, and it drives its data output only while selected. As a master, a low select level means another initiator has claimed the bus. The block then flags a fault, abandons any byte in flight, falls back to the slave role and releases the clock and data lines. Serial inputs pass through two-flop synchronizers, so the slave-side logic runs entirely on the system clock.

Top module: `spi_node`

## Requirements
- R1: After reset the block is a slave with busy, done, wr_collide and mode_fault low, all three output enables low and rd_data equal to 0.
- R2: A master write while idle starts a transfer. wr_data leaves on mosi_o MSB first while miso_i is captured MSB first. done is high for exactly one cycle after the eighth bit, and rd_data then holds the received byte.
- R3: In master mode the clock idles low. Each high and each low phase lasts 2^ctl_div system cycles, so the clock is high for 8*2^ctl_div cycles per byte.
- R4: With ctl_ssm=0, a slave is selected while nss_i is low. miso_oe is high only while the block is a selected slave. A selected slave exchanges its preloaded byte with the master's byte.
- R5: With ctl_ssm=1 the select level is taken from ctl_ssi (0 = selected) and nss_i has no effect.
- R6: A master whose effective select level is low sets mode_fault. It then clears is_master, drops busy and lowers sck_oe and mosi_oe. mode_fault stays set until the next control write.
- R7: Deselecting a slave clears its bit position, so the next selection starts again at bit 7 even after a partial byte.
- R8: A data write while busy is high is ignored, the byte in flight is unchanged, and wr_collide pulses for one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_we | input | 1 | Load the control fields below and clear mode_fault |
| ctl_master | input | 1 | Role: 1 = master, 0 = slave |
| ctl_ssm | input | 1 | Select source: 1 = ctl_ssi, 0 = nss_i |
| ctl_ssi | input | 1 | Internal select level (active low) |
| ctl_div | input | DIVW | Log2 of the clock half-period in system cycles |
| wr_en | input | 1 | Load wr_data as the next byte to send |
| wr_data | input | DW | Byte to send |
| rd_data | output | DW | Last byte received |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle pulse when a byte completes |
| wr_collide | output | 1 | One-cycle pulse on a write while busy |
| mode_fault | output | 1 | Sticky master-contention flag |
| is_master | output | 1 | Current role |
| sck_o | output | 1 | Serial clock out |
| sck_oe | output | 1 | Serial clock output enable |
| sck_i | input | 1 | Serial clock in (slave role) |
| mosi_o | output | 1 | Master data out |
| mosi_oe | output | 1 | Master data output enable |
| mosi_i | input | 1 | Master data in (slave role) |
| miso_o | output | 1 | Slave data out |
| miso_oe | output | 1 | Slave data output enable |
| miso_i | input | 1 | Slave data in (master role) |
| nss_i | input | 1 | External active-low select pin |

## Verification
A master instance and a slave instance are wired back to back, and several byte pairs are exchanged at different dividers. All-ones and all-zeros bytes are among them, and both sides' received bytes are checked. A design with a bit-order or phase error returns shifted or mirrored bytes. One with a wrong divider shows the wrong clock-high count. The bench aborts a master mid-byte by pulling its select low, then runs a fresh exchange. A slave that keeps its stale bit position finishes early with a corrupted byte, and a master that keeps driving or stays busy is caught at the enables. Writes during a transfer and the select-source switch are probed at the ports. A design that lets nss_i leak through under internal select, or that accepts a colliding byte, shows a wrong miso_oe or a wrong received byte.

// File: rtl/spi_node.sv
module spi_node #(
  parameter int DW   = 8,
  parameter int DIVW = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ctl_we,
  input  logic            ctl_master,
  input  logic            ctl_ssm,
  input  logic            ctl_ssi,
  input  logic [DIVW-1:0] ctl_div,
  input  logic            wr_en,
  input  logic [DW-1:0]   wr_data,
  output logic [DW-1:0]   rd_data,
  output logic            busy,
  output logic            done,
  output logic            wr_collide,
  output logic            mode_fault,
  output logic            is_master,
  output logic            sck_o,
  output logic            sck_oe,
  input  logic            sck_i,
  output logic            mosi_o,
  output logic            mosi_oe,
  input  logic            mosi_i,
  output logic            miso_o,
  output logic            miso_oe,
  input  logic            miso_i,
  input  logic            nss_i
);

  localparam int BW = $clog2(DW);
  localparam int CW = (1 << DIVW);

  logic            role_m, ssm_q, ssi_q, fault, active, sck_q, smp;
  logic [DIVW-1:0] div_q;
  logic [DW-1:0]   shreg;
  logic [BW-1:0]   bitcnt;
  logic [CW-1:0]   cnt;
  logic [2:0]      sck_s;
  logic [1:0]      mosi_s, nss_s;

  wire sel_n  = ssm_q ? ssi_q : nss_s[1];
  wire tick   = (cnt == ((CW'(1) << div_q) - CW'(1)));
  wire s_rise = sck_s[1] & ~sck_s[2];
  wire s_fall = ~sck_s[1] & sck_s[2];
  wire last   = (bitcnt == BW'(DW - 1));
  wire [DW-1:0] nxt = {shreg[DW-2:0], smp};

  assign busy       = active;
  assign mode_fault = fault;
  assign is_master  = role_m;
  assign sck_o      = sck_q;
  assign sck_oe     = role_m;
  assign mosi_o     = shreg[DW-1];
  assign mosi_oe    = role_m;
  assign miso_o     = shreg[DW-1];
  assign miso_oe    = ~role_m & ~sel_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      role_m <= 1'b0; ssm_q <= 1'b0; ssi_q <= 1'b1; div_q <= '0;
      fault <= 1'b0; active <= 1'b0; sck_q <= 1'b0; smp <= 1'b0;
      shreg <= '0; bitcnt <= '0; cnt <= '0; rd_data <= '0;
      done <= 1'b0; wr_collide <= 1'b0;
      sck_s <= '0; mosi_s <= '0; nss_s <= 2'b11;
    end else begin
      done       <= 1'b0;
      wr_collide <= 1'b0;
      sck_s      <= {sck_s[1:0], sck_i};
      mosi_s     <= {mosi_s[0], mosi_i};
      nss_s      <= {nss_s[0], nss_i};
      if (ctl_we) begin
        role_m <= ctl_master; ssm_q <= ctl_ssm; ssi_q <= ctl_ssi; div_q <= ctl_div;
        fault <= 1'b0; active <= 1'b0; bitcnt <= '0; sck_q <= 1'b0; cnt <= '0;
      end else if (role_m && !sel_n) begin
        fault <= 1'b1; role_m <= 1'b0; active <= 1'b0;
        bitcnt <= '0; sck_q <= 1'b0; cnt <= '0;
      end else begin
        if (wr_en) begin
          if (active) wr_collide <= 1'b1;
          else begin
            shreg <= wr_data;
            if (role_m) begin active <= 1'b1; cnt <= '0; end
          end
        end
        if (role_m && active) begin
          if (tick) begin
            cnt <= '0;
            if (!sck_q) begin
              sck_q <= 1'b1;
              smp   <= miso_i;
            end else begin
              sck_q  <= 1'b0;
              shreg  <= nxt;
              bitcnt <= bitcnt + BW'(1);
              if (last) begin active <= 1'b0; done <= 1'b1; rd_data <= nxt; end
            end
          end else begin
            cnt <= cnt + CW'(1);
          end
        end else if (!role_m) begin
          if (sel_n) begin
            bitcnt <= '0;
            active <= 1'b0;
          end else begin
            if (s_rise) begin smp <= mosi_s[1]; active <= 1'b1; end
            if (s_fall && active) begin
              shreg  <= nxt;
              bitcnt <= bitcnt + BW'(1);
              if (last) begin active <= 1'b0; done <= 1'b1; rd_data <= nxt; end
            end
          end
        end
      end
    end
  end

  a_r2_done_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r3_sck_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    (is_master && !busy) |-> !sck_o);
  a_r6_fault_releases: assert property (@(posedge clk) disable iff (!rst_n)
    mode_fault |-> (!sck_oe && !mosi_oe));
  a_r4_single_driver: assert property (@(posedge clk) disable iff (!rst_n)
    miso_oe |-> !sck_oe);
  a_r8_collide_needs_busy: assert property (@(posedge clk) disable iff (!rst_n)
    wr_collide |-> $past(busy));
  a_r7_deselect_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (!is_master && !miso_oe) |=> (bitcnt == '0));

endmodule

// File: tb/spi_node_tb.sv
module spi_node_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  int tests = 0;
  int fails = 0;

  logic       m_we = 0, m_master = 0, m_ssm = 0, m_ssi = 1, m_wr = 0, m_nss = 1;
  logic [2:0] m_div = 0;
  logic [7:0] m_wdata = 0, m_rd;
  logic       m_busy, m_done, m_col, m_fault, m_ism, m_sck, m_sckoe, m_mosi, m_mosioe, m_miso, m_misooe;

  logic       p_we = 0, p_master = 0, p_ssm = 0, p_ssi = 1, p_wr = 0, s_nss = 1;
  logic [2:0] p_div = 0;
  logic [7:0] p_wdata = 0, p_rd;
  logic       p_busy, p_done, p_col, p_fault, p_ism, p_sck, p_sckoe, p_mosi, p_mosioe, p_miso, p_misooe;

  wire line_sck  = m_sckoe ? m_sck : 1'b0;
  wire line_mosi = m_mosioe ? m_mosi : 1'b0;
  wire line_miso = p_misooe ? p_miso : 1'b1;

  spi_node u_dut (
    .clk(clk), .rst_n(rst_n), .ctl_we(m_we), .ctl_master(m_master), .ctl_ssm(m_ssm),
    .ctl_ssi(m_ssi), .ctl_div(m_div), .wr_en(m_wr), .wr_data(m_wdata), .rd_data(m_rd),
    .busy(m_busy), .done(m_done), .wr_collide(m_col), .mode_fault(m_fault), .is_master(m_ism),
    .sck_o(m_sck), .sck_oe(m_sckoe), .sck_i(1'b0), .mosi_o(m_mosi), .mosi_oe(m_mosioe),
    .mosi_i(1'b0), .miso_o(m_miso), .miso_oe(m_misooe), .miso_i(line_miso), .nss_i(m_nss));

  spi_node u_peer (
    .clk(clk), .rst_n(rst_n), .ctl_we(p_we), .ctl_master(p_master), .ctl_ssm(p_ssm),
    .ctl_ssi(p_ssi), .ctl_div(p_div), .wr_en(p_wr), .wr_data(p_wdata), .rd_data(p_rd),
    .busy(p_busy), .done(p_done), .wr_collide(p_col), .mode_fault(p_fault), .is_master(p_ism),
    .sck_o(p_sck), .sck_oe(p_sckoe), .sck_i(line_sck), .mosi_o(p_mosi), .mosi_oe(p_mosioe),
    .mosi_i(line_mosi), .miso_o(p_miso), .miso_oe(p_misooe), .miso_i(1'b0), .nss_i(s_nss));

  int p_done_cnt = 0;
  always @(negedge clk) if (p_done) p_done_cnt++;

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cfg_m(input logic ms, input logic ss, input logic si, input logic [2:0] d);
    m_master = ms; m_ssm = ss; m_ssi = si; m_div = d; m_we = 1;
    @(negedge clk); m_we = 0;
  endtask

  task automatic cfg_p(input logic ss, input logic si);
    p_master = 0; p_ssm = ss; p_ssi = si; p_we = 1;
    @(negedge clk); p_we = 0;
  endtask

  task automatic p_load(input logic [7:0] v);
    p_wr = 1; p_wdata = v; @(negedge clk); p_wr = 0;
  endtask

  task automatic xfer(input logic [2:0] d, input logic [7:0] mt, input logic [7:0] st, input string tag);
    int hi;
    int pd0;
    p_load(st);
    repeat (4) @(negedge clk);
    pd0 = p_done_cnt;
    m_wr = 1; m_wdata = mt; @(negedge clk); m_wr = 0;
    hi = 0;
    while (!m_done) begin
      if (m_sck) hi++;
      @(negedge clk);
    end
    chk({tag, " R2 master rx"}, m_rd, st);
    chk({tag, " R3 sck high cycles"}, hi, 8 << d);
    @(negedge clk);
    chk({tag, " R2 done one cycle"}, m_done, 0);
    repeat (8) @(negedge clk);
    chk({tag, " R4 slave rx"}, p_rd, mt);
    chk({tag, " R2 slave done once"}, p_done_cnt, pd0 + 1);
  endtask

  localparam logic [18:0] VEC [0:5] = '{
    {3'd2, 8'hA5, 8'h3C}, {3'd2, 8'hFF, 8'h00}, {3'd3, 8'h00, 8'hFF},
    {3'd3, 8'h81, 8'h7E}, {3'd2, 8'h96, 8'h69}, {3'd4, 8'hC3, 8'h5A}};

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 busy", m_busy, 0);
    chk("R1 is_master", m_ism, 0);
    chk("R1 enables", {m_sckoe, m_mosioe, m_misooe}, 0);
    chk("R1 rd_data", m_rd, 0);
    chk("R1 flags", {m_done, m_col, m_fault}, 0);
    rst_n = 1;
    @(negedge clk);

    cfg_p(1'b0, 1'b1);
    cfg_m(1'b1, 1'b1, 1'b1, 3'd2);
    repeat (4) @(negedge clk);
    chk("R4 deselected miso_oe", p_misooe, 0);
    s_nss = 0; repeat (4) @(negedge clk);
    chk("R4 selected miso_oe", p_misooe, 1);

    for (int i = 0; i < 6; i++) begin
      cfg_m(1'b1, 1'b1, 1'b1, VEC[i][18:16]);
      xfer(VEC[i][18:16], VEC[i][15:8], VEC[i][7:0], "vec");
    end

    // R8: write during a transfer is dropped
    cfg_m(1'b1, 1'b1, 1'b1, 3'd2);
    p_load(8'h11);
    repeat (4) @(negedge clk);
    m_wr = 1; m_wdata = 8'h5A; @(negedge clk); m_wr = 0;
    repeat (3) @(negedge clk);
    m_wr = 1; m_wdata = 8'h00; @(negedge clk); m_wr = 0;
    chk("R8 collide pulse", m_col, 1);
    @(negedge clk);
    chk("R8 collide one cycle", m_col, 0);
    while (!m_done) @(negedge clk);
    repeat (8) @(negedge clk);
    chk("R8 byte unchanged at slave", p_rd, 8'h5A);
    chk("R8 master rx", m_rd, 8'h11);

    // R5: internal select wins over the pin
    s_nss = 1;
    cfg_p(1'b1, 1'b0);
    repeat (4) @(negedge clk);
    chk("R5 ssi selects with pin high", p_misooe, 1);
    xfer(3'd2, 8'h3E, 8'hD4, "R5");
    cfg_p(1'b1, 1'b1);
    s_nss = 0; repeat (4) @(negedge clk);
    chk("R5 ssi deselects with pin low", p_misooe, 0);

    // R6: contention through the pin, mid-transfer
    cfg_p(1'b0, 1'b1);
    cfg_m(1'b1, 1'b0, 1'b1, 3'd2);
    repeat (4) @(negedge clk);
    chk("R6 no fault with pin high", m_fault, 0);
    p_load(8'hF0);
    repeat (4) @(negedge clk);
    m_wr = 1; m_wdata = 8'hAA; @(negedge clk); m_wr = 0;
    repeat (20) @(negedge clk);
    m_nss = 0; repeat (4) @(negedge clk);
    chk("R6 fault set", m_fault, 1);
    chk("R6 role dropped", m_ism, 0);
    chk("R6 busy dropped", m_busy, 0);
    chk("R6 lines released", {m_sckoe, m_mosioe}, 0);
    m_nss = 1; s_nss = 1; repeat (4) @(negedge clk);
    chk("R6 fault sticky", m_fault, 1);
    cfg_m(1'b1, 1'b1, 1'b1, 3'd2);
    chk("R6 cleared by control write", m_fault, 0);

    // R7: fresh selection after a partial byte starts at bit 7
    s_nss = 0;
    xfer(3'd2, 8'hC6, 8'h1B, "R7");
    s_nss = 1;

    // R6: contention through the internal bit
    cfg_m(1'b1, 1'b1, 1'b0, 3'd2);
    repeat (2) @(negedge clk);
    chk("R6 ssi low faults master", {m_fault, m_ism}, 2'b10);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule